// File: doc/BRIEF.md
# Register-Programmed Memory Copy Channel

This block is a single-channel copy engine that moves a run of bytes from one memory region to another. A requester programs a source address, a destination address and a byte count through a small register file, then sets a start bit in the mode register. The engine then works through the run on a word-wide memory port, one outstanding request at a time. Each beat is a read from the source followed by a write to the destination.

While the copy runs, the status register shows a busy flag. When busy drops, any non-zero status value means the copy failed. Status error bits are cleared by writing ones to them. Addresses wider than 32 bits take their upper bits from two separate high-address registers. The start bit is not cleared by the hardware, so the requester clears it before programming the next copy. Copies larger than the count register can hold are split into several runs by the requester.

Top module: `dma_copy_chan`

## Requirements
- R1: After reset every register reads zero and no memory request is raised. Select map: 0 mode (bit 0 = start), 1 status, 2 source low, 3 destination low, 4 source high, 5 destination high, 6 count. Select 7 reads zero.
- R2: The count register keeps only the low CNT_W bits (26 by default) of a write, so writing 0xFFFFFFFF reads back 0x3FFFFFF.
- R3: A mode write with bit 0 set, made while the start bit is clear and the channel is idle, launches a copy. Status bit 0 (busy) reads one from the next cycle until the copy ends. A mode write with bit 0 clear launches nothing.
- R4: A finished copy leaves destination bytes 0..count-1 equal to the source bytes. No other memory byte is written.
- R5: When the source address, the destination address and the count are all multiples of 4, every beat moves a full word with byte enables 4'hF. Otherwise every beat moves one byte, with a single byte enable at lane addr[1:0]. A request stays asserted with a stable address until its response arrives.
- R6: Each memory address is {high register, low register} for its side (source for reads, destination for writes).
- R7: Status bit 1 records a read error and bit 2 a write error. Writing a one to either bit clears it, so writing 0xFFFFFFFF clears both.
- R8: An error response ends the copy: busy clears on the next cycle, the matching error bit is set, and no further request is issued.
- R9: The start bit stays set after the copy completes. Writing start=1 again while it is set launches nothing. Writing mode 0 clears it.
- R10: Writes to the address, high-address and count registers while busy have no effect. Their read-back values and the copy in flight are unchanged.
- R11: Launching with a count of zero sets no busy flag and issues no memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| mem_req | output | 1 | Memory request, held until the response |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | ADDR_W | Byte address of the beat |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with the response |
| mem_rsp_valid | input | 1 | Response for the current request |
| mem_rsp_err | input | 1 | Response carries an error |

## Verification
The bench builds the block with ADDR_W = 36 and CNT_W left at 26. The four-bit high-address registers then show up directly in the top nibble of every memory address, and the count truncation check sees the full 26-bit limit. Copies of 7 to 16 bytes within a 256-byte memory model cover both the word path and the byte path. The model can inject an error response on any chosen beat, which places errors on read beats and on write beats alike.

// File: rtl/dma_copy_pkg.sv
package dma_copy_pkg;
  typedef enum logic [1:0] {
    MV_IDLE  = 2'd0,
    MV_READ  = 2'd1,
    MV_WRITE = 2'd2
  } mv_state_e;

  localparam logic [2:0] SEL_MODE   = 3'd0;
  localparam logic [2:0] SEL_STAT   = 3'd1;
  localparam logic [2:0] SEL_SRC_LO = 3'd2;
  localparam logic [2:0] SEL_DST_LO = 3'd3;
  localparam logic [2:0] SEL_SRC_HI = 3'd4;
  localparam logic [2:0] SEL_DST_HI = 3'd5;
  localparam logic [2:0] SEL_COUNT  = 3'd6;

  localparam int STAT_BUSY_BIT = 0;
  localparam int STAT_RERR_BIT = 1;
  localparam int STAT_WERR_BIT = 2;
endpackage

// File: rtl/dma_copy_rst_sync.sv
module dma_copy_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/dma_copy_regs.sv
module dma_copy_regs
  import dma_copy_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int CNT_W  = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              busy_i,
  input  logic              rd_err_i,
  input  logic              wr_err_i,
  output logic              launch_o,
  output logic [ADDR_W-1:0] src_o,
  output logic [ADDR_W-1:0] dst_o,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam int HI_W = ADDR_W - 32;

  logic            start_q, start_d;
  logic [31:0]     src_lo_q, dst_lo_q;
  logic [HI_W-1:0] src_hi_q, dst_hi_q;
  logic [CNT_W-1:0] cnt_q;
  logic            rerr_q, rerr_d, werr_q, werr_d;

  logic cfg_open;
  logic mode_wr, stat_wr;
  logic en_src_lo, en_dst_lo, en_src_hi, en_dst_hi, en_cnt;

  always_comb begin
    cfg_open  = !busy_i;
    mode_wr   = reg_we && (reg_sel == SEL_MODE) && cfg_open;
    stat_wr   = reg_we && (reg_sel == SEL_STAT);
    en_src_lo = reg_we && (reg_sel == SEL_SRC_LO) && cfg_open;
    en_dst_lo = reg_we && (reg_sel == SEL_DST_LO) && cfg_open;
    en_src_hi = reg_we && (reg_sel == SEL_SRC_HI) && cfg_open;
    en_dst_hi = reg_we && (reg_sel == SEL_DST_HI) && cfg_open;
    en_cnt    = reg_we && (reg_sel == SEL_COUNT)  && cfg_open;

    start_d  = mode_wr ? reg_wdata[0] : start_q;
    launch_o = mode_wr && reg_wdata[0] && !start_q;

    rerr_d = rerr_q;
    if (stat_wr && reg_wdata[STAT_RERR_BIT]) rerr_d = 1'b0;
    if (rd_err_i) rerr_d = 1'b1;
    werr_d = werr_q;
    if (stat_wr && reg_wdata[STAT_WERR_BIT]) werr_d = 1'b0;
    if (wr_err_i) werr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q  <= 1'b0;
      rerr_q   <= 1'b0;
      werr_q   <= 1'b0;
      src_lo_q <= '0;
      dst_lo_q <= '0;
      src_hi_q <= '0;
      dst_hi_q <= '0;
      cnt_q    <= '0;
    end else begin
      start_q <= start_d;
      rerr_q  <= rerr_d;
      werr_q  <= werr_d;
      if (en_src_lo) src_lo_q <= reg_wdata;
      if (en_dst_lo) dst_lo_q <= reg_wdata;
      if (en_src_hi) src_hi_q <= reg_wdata[HI_W-1:0];
      if (en_dst_hi) dst_hi_q <= reg_wdata[HI_W-1:0];
      if (en_cnt)    cnt_q    <= reg_wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      SEL_MODE:   reg_rdata = {31'd0, start_q};
      SEL_STAT:   reg_rdata = {29'd0, werr_q, rerr_q, busy_i};
      SEL_SRC_LO: reg_rdata = src_lo_q;
      SEL_DST_LO: reg_rdata = dst_lo_q;
      SEL_SRC_HI: reg_rdata = {{(32-HI_W){1'b0}}, src_hi_q};
      SEL_DST_HI: reg_rdata = {{(32-HI_W){1'b0}}, dst_hi_q};
      SEL_COUNT:  reg_rdata = {{(32-CNT_W){1'b0}}, cnt_q};
      default:    reg_rdata = '0;
    endcase
  end

  assign src_o = {src_hi_q, src_lo_q};
  assign dst_o = {dst_hi_q, dst_lo_q};
  assign cnt_o = cnt_q;

  p_cfg_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i && reg_we && (reg_sel == SEL_SRC_LO) |=> $stable(src_lo_q));

  p_start_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_i) |-> start_q);

  p_w1c_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we && (reg_sel == SEL_STAT) && (reg_wdata == 32'hFFFF_FFFF) && !rd_err_i && !wr_err_i
    |=> !rerr_q && !werr_q);
endmodule

// File: rtl/dma_copy_mover.sv
module dma_copy_mover
  import dma_copy_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int CNT_W  = 26,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_i,
  input  logic [ADDR_W-1:0] src_i,
  input  logic [ADDR_W-1:0] dst_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              busy_o,
  output logic              rd_err_o,
  output logic              wr_err_o,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W/8-1:0] mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_rsp_valid,
  input  logic              mem_rsp_err
);
  localparam int BE_W   = DATA_W / 8;
  localparam int LANE_W = $clog2(BE_W);

  mv_state_e         state_q, state_d;
  logic [ADDR_W-1:0] src_q, src_d, dst_q, dst_d;
  logic [CNT_W-1:0]  rem_q, rem_d, step;
  logic              word_q, word_d;
  logic [DATA_W-1:0] buf_q, buf_d;
  logic              load_en, cap_en, adv_en;
  logic [7:0]        rd_byte;
  logic [LANE_W-1:0] lane;

  always_comb begin
    step    = word_q ? CNT_W'(BE_W) : CNT_W'(1);
    rd_byte = mem_rdata[src_q[LANE_W-1:0]*8 +: 8];
    state_d = state_q;
    src_d   = src_q;
    dst_d   = dst_q;
    rem_d   = rem_q;
    word_d  = word_q;
    buf_d   = buf_q;
    load_en = 1'b0;
    cap_en  = 1'b0;
    adv_en  = 1'b0;
    rd_err_o = 1'b0;
    wr_err_o = 1'b0;
    case (state_q)
      MV_IDLE: begin
        if (launch_i && (cnt_i != '0)) begin
          load_en = 1'b1;
          src_d   = src_i;
          dst_d   = dst_i;
          rem_d   = cnt_i;
          word_d  = (src_i[LANE_W-1:0] == '0) && (dst_i[LANE_W-1:0] == '0)
                    && (cnt_i[LANE_W-1:0] == '0);
          state_d = MV_READ;
        end
      end
      MV_READ: begin
        if (mem_rsp_valid) begin
          if (mem_rsp_err) begin
            rd_err_o = 1'b1;
            state_d  = MV_IDLE;
          end else begin
            cap_en  = 1'b1;
            buf_d   = word_q ? mem_rdata : {BE_W{rd_byte}};
            state_d = MV_WRITE;
          end
        end
      end
      MV_WRITE: begin
        if (mem_rsp_valid) begin
          if (mem_rsp_err) begin
            wr_err_o = 1'b1;
            state_d  = MV_IDLE;
          end else begin
            adv_en  = 1'b1;
            src_d   = src_q + ADDR_W'(step);
            dst_d   = dst_q + ADDR_W'(step);
            rem_d   = rem_q - step;
            state_d = (rem_q == step) ? MV_IDLE : MV_READ;
          end
        end
      end
      default: state_d = MV_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MV_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      rem_q   <= '0;
      word_q  <= 1'b0;
      buf_q   <= '0;
    end else begin
      state_q <= state_d;
      if (load_en || adv_en) begin
        src_q <= src_d;
        dst_q <= dst_d;
        rem_q <= rem_d;
      end
      if (load_en) word_q <= word_d;
      if (cap_en)  buf_q  <= buf_d;
    end
  end

  always_comb begin
    busy_o    = (state_q != MV_IDLE);
    mem_req   = busy_o;
    mem_we    = (state_q == MV_WRITE);
    mem_addr  = mem_we ? dst_q : src_q;
    lane      = mem_addr[LANE_W-1:0];
    mem_be    = word_q ? {BE_W{1'b1}} : (BE_W'(1) << lane);
    mem_wdata = buf_q;
  end

  p_req_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_rsp_valid |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  p_full_word_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && (mem_be == {BE_W{1'b1}}) |-> (mem_addr[LANE_W-1:0] == '0));

  p_err_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && mem_rsp_valid && mem_rsp_err |=> !busy_o);

  p_busy_from_launch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(launch_i));

  p_zero_count_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && launch_i && (cnt_i == '0) |=> !busy_o);
endmodule

// File: rtl/dma_copy_chan.sv
module dma_copy_chan #(
  parameter int ADDR_W = 40,
  parameter int CNT_W  = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_rsp_valid,
  input  logic              mem_rsp_err
);
  logic              rst_n_s;
  logic              busy, rd_err, wr_err, launch;
  logic [ADDR_W-1:0] src, dst;
  logic [CNT_W-1:0]  cnt;

  dma_copy_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s)
  );

  dma_copy_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) regs_i (
    .clk(clk), .rst_n(rst_n_s),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .busy_i(busy), .rd_err_i(rd_err), .wr_err_i(wr_err),
    .launch_o(launch), .src_o(src), .dst_o(dst), .cnt_o(cnt)
  );

  dma_copy_mover #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(32)) mover_i (
    .clk(clk), .rst_n(rst_n_s),
    .launch_i(launch), .src_i(src), .dst_i(dst), .cnt_i(cnt),
    .busy_o(busy), .rd_err_o(rd_err), .wr_err_o(wr_err),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_err(mem_rsp_err)
  );

  p_no_req_in_reset_r1: assert property (@(posedge clk)
    !rst_n_s |-> !mem_req);
endmodule

// File: tb/dma_copy_chan_tb.sv
module dma_copy_chan_tb_top;
  localparam int AW = 36;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_rsp_valid = 1'b0;
  logic        mem_rsp_err = 1'b0;

  int n_checks = 0;
  int n_fail = 0;
  logic done = 1'b0;

  logic [7:0] mem [256];
  logic [7:0] img [256];
  int beats = 0, wbeats = 0, wfull = 0, wone = 0, inject_at = 0;
  logic [3:0] last_rd_hi = '0, last_wr_hi = '0;

  always #10 clk = ~clk;

  dma_copy_chan #(.ADDR_W(AW), .CNT_W(26)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_err(mem_rsp_err)
  );

  always @(posedge clk) begin
    if (mem_rsp_valid) begin
      mem_rsp_valid <= 1'b0;
      mem_rsp_err   <= 1'b0;
    end else if (mem_req) begin
      beats = beats + 1;
      mem_rsp_valid <= 1'b1;
      mem_rsp_err   <= (beats == inject_at);
      if (mem_we) begin
        last_wr_hi = mem_addr[AW-1:32];
        wbeats = wbeats + 1;
        if (mem_be == 4'hF) wfull = wfull + 1;
        if ($onehot(mem_be)) wone = wone + 1;
        if (beats != inject_at)
          for (int l = 0; l < 4; l++)
            if (mem_be[l]) mem[{mem_addr[7:2], 2'(l)}] = mem_wdata[l*8 +: 8];
      end else begin
        last_rd_hi = mem_addr[AW-1:32];
        mem_rdata <= {mem[{mem_addr[7:2], 2'd3}], mem[{mem_addr[7:2], 2'd2}],
                      mem[{mem_addr[7:2], 2'd1}], mem[{mem_addr[7:2], 2'd0}]};
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [31:0] d);
    @(negedge clk);
    reg_sel = s;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] st;
    for (int i = 0; i < 2000; i++) begin
      rd(3'd1, st);
      if (!st[0]) return;
    end
    n_checks++; n_fail++;
    $display("FAIL R3: busy never cleared");
  endtask

  task automatic fill_mem();
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i) ^ 8'h5A;
      img[i] = mem[i];
    end
    beats = 0; wbeats = 0; wfull = 0; wone = 0; inject_at = 0;
  endtask

  task automatic cmp_mem(input string req);
    int bad = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== img[i]) bad++;
    chk(req, bad, 0);
  endtask

  task automatic setup(input int s, input int d, input int n, input int shi, input int dhi);
    wr(3'd0, 32'd0);
    wr(3'd2, s); wr(3'd3, d); wr(3'd4, shi); wr(3'd5, dhi); wr(3'd6, n);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int s = 0; s < 8; s++) begin
      rd(3'(s), v);
      chk("R1 reg reset", v, 0);
    end
    chk("R1 no request", {31'd0, mem_req}, 0);
  endtask

  task automatic t_count_width();
    logic [31:0] v;
    wr(3'd6, 32'hFFFF_FFFF);
    rd(3'd6, v);
    chk("R2 count width", v, 32'h03FF_FFFF);
  endtask

  task automatic t_word_copy();
    logic [31:0] v;
    fill_mem();
    setup(32'h10, 32'h80, 16, 3, 5);
    wr(3'd0, 32'd0);
    repeat (3) @(negedge clk);
    chk("R3 no launch without start", beats, 0);
    wr(3'd0, 32'd1);
    rd(3'd1, v);
    chk("R3 busy during copy", v[0], 1);
    wait_idle();
    for (int i = 0; i < 16; i++) img[8'h80 + i] = img[8'h10 + i];
    cmp_mem("R4 word copy data");
    chk("R5 word beats", wbeats, 4);
    chk("R5 full byte enables", wfull, 4);
    chk("R6 source high bits", last_rd_hi, 3);
    chk("R6 dest high bits", last_wr_hi, 5);
    rd(3'd1, v);
    chk("R3 status clean", v, 0);
    rd(3'd0, v);
    chk("R9 start held", v, 1);
  endtask

  task automatic t_byte_copy_frozen();
    logic [31:0] v;
    fill_mem();
    setup(32'h21, 32'hA3, 7, 0, 0);
    wr(3'd0, 32'd1);
    wr(3'd2, 32'h99);
    wr(3'd6, 32'd1);
    rd(3'd2, v);
    chk("R10 source frozen", v, 32'h21);
    rd(3'd6, v);
    chk("R10 count frozen", v, 7);
    wait_idle();
    for (int i = 0; i < 7; i++) img[8'hA3 + i] = img[8'h21 + i];
    cmp_mem("R4 byte copy data");
    chk("R5 byte beats", wbeats, 7);
    chk("R5 single enables", wone, 7);
    beats = 0;
    wr(3'd0, 32'd1);
    repeat (4) @(negedge clk);
    chk("R9 restart ignored", beats, 0);
    wr(3'd0, 32'd0);
    rd(3'd0, v);
    chk("R9 start cleared", v, 0);
  endtask

  task automatic t_errors();
    logic [31:0] v;
    fill_mem();
    setup(32'h40, 32'hC0, 12, 0, 0);
    inject_at = 3;
    wr(3'd0, 32'd1);
    wait_idle();
    repeat (4) @(negedge clk);
    chk("R8 stop after read error", beats, 3);
    for (int i = 0; i < 4; i++) img[8'hC0 + i] = img[8'h40 + i];
    cmp_mem("R8 partial data");
    rd(3'd1, v);
    chk("R7 read error bit", v, 32'h2);
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, v);
    chk("R7 cleared", v, 0);
    fill_mem();
    inject_at = 2;
    wr(3'd0, 32'd0);
    wr(3'd0, 32'd1);
    wait_idle();
    rd(3'd1, v);
    chk("R8 write error bit", v, 32'h4);
    chk("R8 no further beats", beats, 2);
    wr(3'd1, 32'h4);
    rd(3'd1, v);
    chk("R7 write error cleared", v, 0);
  endtask

  task automatic t_zero();
    logic [31:0] v;
    fill_mem();
    setup(32'h10, 32'h20, 0, 0, 0);
    wr(3'd0, 32'd1);
    rd(3'd1, v);
    chk("R11 no busy", v, 0);
    repeat (4) @(negedge clk);
    chk("R11 no request", beats, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_count_width();
    t_word_copy();
    t_byte_copy_frozen();
    t_errors();
    t_zero();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not finish");
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule